// File: doc/BRIEF.md
# Two-Digit Decimal Up/Down Scoreboard

This block keeps a score from 0 to 99 as a tens digit and a units digit, each in BCD. On each rising clock edge it applies at most one step. A lone increment request adds one, and a lone decrement request takes one away, so an operator can undo a mistaken point. When both requests arrive together, they cancel. Each digit also drives its own seven-segment pattern, ready for a display.

Clearing the score is guarded against accidental presses. The clear request has effect only after it has been sampled high on five back-to-back clock edges. Any gap restarts the count. A separate asynchronous active-low reset puts the whole block into its power-on state.

Top module: `score_board`

## Requirements
- R1: After `rst_n` is low, both digits read 0. Each digit always stays in 0..9, so the score stays within 0..99.
- R2: An edge that samples `inc_req` high, `dec_req` low and no clear raises the score by one. When the units digit is 9 it goes to 0 and the tens digit goes up by one.
- R3: An edge that samples `dec_req` high, `inc_req` low and no clear lowers the score by one. When the units digit is 0 it goes to 9 and the tens digit goes down by one.
- R4: An edge that samples `inc_req` and `dec_req` both high, with no clear, leaves both digits unchanged.
- R5: On the fifth consecutive edge that samples `clear_req` high, the score becomes 0, whatever the step requests are. It remains 0 on every further edge while `clear_req` stays high.
- R6: A run of fewer than five consecutive high samples of `clear_req` does not change the score. A low sample restarts the count from zero.
- R7: An increment at 99 keeps the score at 99. A decrement at 0 keeps the score at 0.
- R8: The segment outputs are active-high, with bit 0 = a through bit 6 = g. The hex values for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_req | input | 1 | Request to add one point |
| dec_req | input | 1 | Request to remove one point |
| clear_req | input | 1 | Guarded request to zero the score |
| tens_bcd | output | 4 | Tens digit, BCD |
| units_bcd | output | 4 | Units digit, BCD |
| tens_seg | output | 7 | Tens segments, bit 0 = a .. bit 6 = g |
| units_seg | output | 7 | Units segments, bit 0 = a .. bit 6 = g |

## Verification
The assertions check on every cycle that:
- each digit stays in range;
- every lone step moves the decimal value by exactly one, or holds it at a limit;
- cancelled requests leave the score stable;
- a fired clear yields zero;
- the hold counter stays in bounds and restarts when the request drops.

Only the bench's scenarios can show some of these behaviours:
- that exactly five edges are needed before a clear;
- that a broken run of four does nothing;
- that the full sequence across all carries and borrows is right.

They also confirm the segment patterns, which the bench compares against its own table for every value the score passes through.

// File: rtl/score_pkg.sv
package score_pkg;

  typedef logic [3:0] bcd_t;

  typedef struct packed {
    bcd_t tens;
    bcd_t units;
  } score_t;

  localparam bcd_t DIGIT_MAX = 4'd9;

  function automatic int unsigned score_value(input score_t s);
    return 32'(s.tens) * 10 + 32'(s.units);
  endfunction

  function automatic score_t score_up(input score_t s);
    score_t r;
    r = s;
    if (s.units == DIGIT_MAX) begin
      if (s.tens != DIGIT_MAX) begin
        r.units = 4'd0;
        r.tens  = s.tens + 4'd1;
      end
    end else begin
      r.units = s.units + 4'd1;
    end
    return r;
  endfunction

  function automatic score_t score_down(input score_t s);
    score_t r;
    r = s;
    if (s.units == 4'd0) begin
      if (s.tens != 4'd0) begin
        r.units = DIGIT_MAX;
        r.tens  = s.tens - 4'd1;
      end
    end else begin
      r.units = s.units - 4'd1;
    end
    return r;
  endfunction

  // bit 0 = a ... bit 6 = g, active high
  function automatic logic [6:0] seg_pattern(input bcd_t d);
    logic [6:0] p;
    case (d)
      4'd0: p = 7'h3F;
      4'd1: p = 7'h06;
      4'd2: p = 7'h5B;
      4'd3: p = 7'h4F;
      4'd4: p = 7'h66;
      4'd5: p = 7'h6D;
      4'd6: p = 7'h7D;
      4'd7: p = 7'h07;
      4'd8: p = 7'h7F;
      4'd9: p = 7'h6F;
      default: p = 7'h00;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/score_hold_guard.sv
module score_hold_guard #(
  parameter int HOLD_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic fire
);
  localparam int HOLD_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [HOLD_W-1:0] LAST = HOLD_W'(HOLD_CYCLES - 1);

  logic [HOLD_W-1:0] run_cnt;
  logic              run_full;

  assign run_full = (run_cnt == LAST);
  assign fire     = req && run_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!req) begin
      run_cnt <= '0;
    end else if (!run_full) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  p_hold_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= LAST);

  p_hold_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (run_cnt == '0));

  p_hold_climb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !run_full) |=> (run_cnt == $past(run_cnt) + 1'b1));

endmodule

// File: rtl/score_counter.sv
module score_counter
  import score_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   up_req,
  input  logic   dn_req,
  input  logic   wipe,
  output score_t score
);
  logic step_up;
  logic step_dn;
  logic at_max;
  logic at_min;
  score_t nxt;

  assign step_up = up_req && !dn_req && !wipe;
  assign step_dn = dn_req && !up_req && !wipe;
  assign at_max  = (score.tens == DIGIT_MAX) && (score.units == DIGIT_MAX);
  assign at_min  = (score.tens == 4'd0) && (score.units == 4'd0);

  always_comb begin
    nxt = score;
    if (wipe)         nxt = '0;
    else if (step_up) nxt = score_up(score);
    else if (step_dn) nxt = score_down(score);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) score <= '0;
    else        score <= nxt;
  end

  p_digit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (score.tens <= DIGIT_MAX) && (score.units <= DIGIT_MAX));

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !at_max) |=> (score_value(score) == score_value($past(score)) + 1));

  p_step_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !at_min) |=> (score_value(score) + 1 == score_value($past(score))));

  p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && dn_req && !wipe) |=> $stable(score));

  p_wipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (score == '0));

  p_sat_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && at_max) |=> $stable(score));

  p_sat_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && at_min) |=> $stable(score));

endmodule

// File: rtl/score_seg_decode.sv
module score_seg_decode
  import score_pkg::*;
(
  input  bcd_t       digit,
  output logic [6:0] seg
);
  assign seg = seg_pattern(digit);
endmodule

// File: rtl/score_board.sv
module score_board
  import score_pkg::*;
#(
  parameter int HOLD_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc_req,
  input  logic       dec_req,
  input  logic       clear_req,
  output logic [3:0] tens_bcd,
  output logic [3:0] units_bcd,
  output logic [6:0] tens_seg,
  output logic [6:0] units_seg
);
  localparam int NUM_DIGITS = 2;

  logic       clear_fire;
  score_t     score;
  bcd_t       digits [NUM_DIGITS];
  logic [6:0] segs   [NUM_DIGITS];

  score_hold_guard #(.HOLD_CYCLES(HOLD_CYCLES)) u_guard (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (clear_req),
    .fire  (clear_fire)
  );

  score_counter u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_req (inc_req),
    .dn_req (dec_req),
    .wipe   (clear_fire),
    .score  (score)
  );

  assign digits[0] = score.units;
  assign digits[1] = score.tens;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
    score_seg_decode u_dec (
      .digit (digits[g]),
      .seg   (segs[g])
    );
  end

  assign units_bcd = score.units;
  assign tens_bcd  = score.tens;
  assign units_seg = segs[0];
  assign tens_seg  = segs[1];

  p_seg_lit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (units_seg != 7'h00) && (tens_seg != 7'h00));

endmodule

// File: tb/sim_score_board.sv
module sim_score_board;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       inc_req, dec_req, clear_req;
  logic [3:0] tens_bcd, units_bcd;
  logic [6:0] tens_seg, units_seg;

  int checks = 0;
  int failures = 0;
  int model_score = 0;
  int model_hold = 0;
  bit done = 0;

  localparam int HOLD = 5;
  logic [6:0] seg_ref [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                               7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};

  always #5 clk = ~clk;

  score_board #(.HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .inc_req(inc_req), .dec_req(dec_req),
    .clear_req(clear_req), .tens_bcd(tens_bcd), .units_bcd(units_bcd),
    .tens_seg(tens_seg), .units_seg(units_seg)
  );

  task automatic compare(input string tag);
    int et, eu;
    et = model_score / 10;
    eu = model_score % 10;
    checks++;
    if (int'(tens_bcd) != et || int'(units_bcd) != eu) begin
      failures++;
      $display("FAIL %s digits actual=%0d%0d expected=%0d%0d", tag, tens_bcd, units_bcd, et, eu);
    end else if (tens_seg != seg_ref[et] || units_seg != seg_ref[eu]) begin
      failures++;
      $display("FAIL R8 (%s) segs actual=%h/%h expected=%h/%h", tag,
               tens_seg, units_seg, seg_ref[et], seg_ref[eu]);
    end
  endtask

  // called just after a falling edge
  task automatic step(input logic i, input logic d, input logic c, input string tag);
    inc_req = i; dec_req = d; clear_req = c;
    @(posedge clk);
    if (c) model_hold = model_hold + 1; else model_hold = 0;
    if (c && model_hold >= HOLD) model_score = 0;
    else if (i && !d) model_score = (model_score < 99) ? model_score + 1 : 99;
    else if (d && !i) model_score = (model_score > 0) ? model_score - 1 : 0;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; inc_req = 0; dec_req = 0; clear_req = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 idle");
    for (int k = 0; k < 23; k++) step(1, 0, 0, "R2 inc");
    for (int k = 0; k < 5; k++) step(1, 1, 0, "R4 both");
    for (int k = 0; k < 14; k++) step(0, 1, 0, "R3 dec");
    for (int k = 0; k < 4; k++) step(0, 0, 1, "R6 short hold");
    step(1, 0, 0, "R6 gap");
    for (int k = 0; k < 4; k++) step(1, 0, 1, "R6 restart");
    step(0, 0, 0, "R6 gap2");
    for (int k = 0; k < 6; k++) step(1, 0, 1, "R5 clear");
    step(0, 0, 0, "R5 release");
    for (int k = 0; k < 3; k++) step(0, 1, 0, "R7 floor");
    for (int k = 0; k < 104; k++) step(1, 0, 0, "R7 ceiling");
    step(1, 1, 0, "R4 at top");
    step(0, 1, 0, "R3 from top");
    step(0, 1, 1, "R6 one");
    for (int k = 0; k < 5; k++) step(0, 1, 1, "R5 clear dec");
    rst_n = 1'b0;
    @(negedge clk);
    model_score = 0; model_hold = 0;
    compare("R1 async reset");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule